// File: doc/BRIEF.md
# Single-Precision Float to 32-bit Integer Converter

This block turns a 32-bit binary floating-point value into a 32-bit integer, either signed (two's complement) or unsigned, chosen per conversion. The conversion rounds according to a 3-bit rounding-mode input. It checks the range of the rounded value. Values that cannot be represented, infinities and NaNs produce fixed saturation results and raise an invalid flag. An inexact flag reports a rounded result that differs from the input, and it is never raised together with invalid.

The block is a single pipeline stage. A conversion is offered with `in_vld`, and the result, its flags and an illegal-mode indication come out registered exactly one cycle later with `out_vld`. Between conversions the output registers keep the last result. Subnormal inputs are fully supported.

Top module: `f2i_conv`

## Requirements
- R1: `in_rmode` encodes 000 = nearest with ties to even, 001 = toward zero, 010 = toward minus infinity, 011 = toward plus infinity, 100 = nearest with ties away from zero, and the integer result follows that rounding of the input value.
- R2: With `in_unsigned` = 0, a rounded value in the range -2^31 to 2^31-1 comes out as its two's-complement 32-bit pattern with `out_invalid` = 0.
- R3: With `in_unsigned` = 1, a rounded value in the range 0 to 2^32-1 comes out as its unsigned 32-bit pattern with `out_invalid` = 0. For any negative input the unsigned result is 0.
- R4: A signed conversion whose rounded value is above 2^31-1, or whose input is +infinity or any NaN, gives 0x7FFFFFFF. One below -2^31, or -infinity, gives 0x80000000. Both set `out_invalid`.
- R5: An unsigned conversion whose rounded value is above 2^32-1, or whose input is +infinity or any NaN, gives 0xFFFFFFFF. A negative rounded value or -infinity gives 0. Both set `out_invalid`.
- R6: The range test applies to the value after rounding. For example, -0.4 unsigned under mode 000 gives 0 with no invalid, and -2^31 signed is valid.
- R7: `out_inexact` is 1 exactly when the rounded value differs from the input and `out_invalid` is 0.
- R8: Inputs of +0 and -0 give 0 with both flags clear.
- R9: Nonzero subnormal inputs give 0, +1 or -1 as the mode dictates, with `out_inexact` set whenever the result is valid.
- R10: `out_illegal` is 1 for an `in_rmode` of 101, 110 or 111, and the result and flags are then unspecified. It is 0 for the five defined modes.
- R11: `out_vld` equals `in_vld` of the previous cycle. Result, flags and illegal indication belong to that conversion.
- R12: In a cycle where no conversion completes, `out_int` keeps its previous value.
- R13: While `rst_n` is low, `out_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | A conversion is offered this cycle |
| in_bits | input | 32 | Floating-point operand |
| in_unsigned | input | 1 | 1 selects an unsigned result, 0 a signed one |
| in_rmode | input | 3 | Rounding mode |
| out_vld | output | 1 | Result registers hold a new conversion |
| out_int | output | 32 | Integer result |
| out_invalid | output | 1 | Result not representable, saturated |
| out_inexact | output | 1 | Rounding changed the value |
| out_illegal | output | 1 | Rounding mode was undefined |

## Verification
The bound assertions check the following on every cycle: the one-cycle valid relationship, the illegal-mode decode, the exclusion between the two flags, the no-flag zero result, the NaN saturation patterns, and the rule that a negative unsigned conversion always returns 0. The rounding of ordinary values under each mode needs the bench's reference model over a range of operands, because it depends on exact numeric values. The same holds for the exact saturation boundaries at 2^31 and 2^32, subnormal behaviour, and the holding of results across idle cycles.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int BIAS  = 127;
  localparam int FP_W  = 1 + EXP_W + MAN_W;

  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_ZERO      = 3'd1,
    RM_DOWN      = 3'd2,
    RM_UP        = 3'd3,
    RM_NEAR_MAX  = 3'd4
  } rmode_e;

  typedef struct packed {
    logic             sign;
    logic             is_nan;
    logic             is_inf;
    logic             is_zero;
    logic [EXP_W-1:0] exp;
    logic [MAN_W:0]   sig;
  } fp_fields_t;
endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
  import f2i_pkg::*;
(
  input  logic [FP_W-1:0] bits,
  output fp_fields_t      fld
);
  logic [EXP_W-1:0] e;
  logic [MAN_W-1:0] m;
  logic             e_max;
  logic             e_min;

  always_comb begin
    e     = bits[FP_W-2 -: EXP_W];
    m     = bits[MAN_W-1:0];
    e_max = &e;
    e_min = ~|e;
    fld.sign    = bits[FP_W-1];
    fld.exp     = e;
    fld.is_nan  = e_max & (|m);
    fld.is_inf  = e_max & ~(|m);
    fld.is_zero = e_min & ~(|m);
    // hidden one only for normal numbers
    fld.sig     = {~e_min, m};
  end
endmodule

// File: rtl/f2i_align_round.sv
module f2i_align_round
  import f2i_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  fp_fields_t       fld,
  input  logic [2:0]       rmode,
  output logic [INT_W:0]   mag,
  output logic             too_big,
  output logic             lost
);
  localparam int QW  = MAN_W + 1 + INT_W;
  localparam int SHW = $clog2(INT_W + 1);

  int               ue;
  logic             tiny;
  logic [SHW-1:0]   shamt;
  logic [QW-1:0]    q;
  logic [INT_W-1:0] ipart;
  logic             guard;
  logic             sticky;
  logic             inc;

  always_comb begin
    ue      = int'(fld.exp) - BIAS;
    too_big = fld.is_nan | fld.is_inf | (ue >= INT_W);
    tiny    = (ue < -1);
    shamt   = (tiny | too_big) ? '0 : SHW'(ue + 1);
    // q holds value * 2^(MAN_W+1): integer part above, fraction below
    q       = QW'(fld.sig) << shamt;
    if (tiny) begin
      ipart  = '0;
      guard  = 1'b0;
      sticky = ~fld.is_zero;
    end else begin
      ipart  = q[QW-1 -: INT_W];
      guard  = q[MAN_W];
      sticky = |q[MAN_W-1:0];
    end
    unique case (rmode)
      RM_NEAR_EVEN: inc = guard & (sticky | ipart[0]);
      RM_ZERO:      inc = 1'b0;
      RM_DOWN:      inc = fld.sign & (guard | sticky);
      RM_UP:        inc = ~fld.sign & (guard | sticky);
      RM_NEAR_MAX:  inc = guard;
      default:      inc = 1'b0;
    endcase
    mag  = {1'b0, ipart} + {{INT_W{1'b0}}, inc};
    lost = guard | sticky;
  end
endmodule

// File: rtl/f2i_saturate.sv
module f2i_saturate #(
  parameter int INT_W = 32
) (
  input  logic             sign,
  input  logic             is_nan,
  input  logic             too_big,
  input  logic             uns,
  input  logic [INT_W:0]   mag,
  input  logic             lost,
  output logic [INT_W-1:0] res,
  output logic             invalid,
  output logic             inexact
);
  localparam logic [INT_W-1:0] UMAX = {INT_W{1'b1}};
  localparam logic [INT_W-1:0] SMAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] SMIN = {1'b1, {(INT_W-1){1'b0}}};

  logic [INT_W:0]   pos_lim;
  logic [INT_W:0]   neg_lim;
  logic [INT_W-1:0] pos_sat;
  logic [INT_W-1:0] neg_sat;

  always_comb begin
    pos_lim = uns ? {1'b0, UMAX} : {1'b0, SMAX};
    neg_lim = uns ? '0 : {1'b0, SMIN};
    pos_sat = uns ? UMAX : SMAX;
    neg_sat = uns ? '0 : SMIN;
    invalid = 1'b1;
    if (is_nan)                      res = pos_sat;
    else if (too_big)                res = sign ? neg_sat : pos_sat;
    else if (!sign && mag > pos_lim) res = pos_sat;
    else if (sign && mag > neg_lim)  res = neg_sat;
    else begin
      invalid = 1'b0;
      res     = sign ? (-mag[INT_W-1:0]) : mag[INT_W-1:0];
    end
    inexact = lost & ~invalid;
  end
endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
  import f2i_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [FP_W-1:0]  in_bits,
  input  logic             in_unsigned,
  input  logic [2:0]       in_rmode,
  output logic             out_vld,
  output logic [INT_W-1:0] out_int,
  output logic             out_invalid,
  output logic             out_inexact,
  output logic             out_illegal
);
  // reset release synchronizer
  logic rst_meta;
  logic rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ok   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ok   <= rst_meta;
    end
  end

  fp_fields_t       fld;
  logic [INT_W:0]   mag;
  logic             too_big;
  logic             lost;
  logic [INT_W-1:0] res;
  logic             inv;
  logic             inx;
  logic             ill;

  f2i_unpack u_unpack (
    .bits (in_bits),
    .fld  (fld)
  );

  f2i_align_round #(.INT_W(INT_W)) u_round (
    .fld     (fld),
    .rmode   (in_rmode),
    .mag     (mag),
    .too_big (too_big),
    .lost    (lost)
  );

  f2i_saturate #(.INT_W(INT_W)) u_sat (
    .sign    (fld.sign),
    .is_nan  (fld.is_nan),
    .too_big (too_big),
    .uns     (in_unsigned),
    .mag     (mag),
    .lost    (lost),
    .res     (res),
    .invalid (inv),
    .inexact (inx)
  );

  assign ill = (in_rmode > 3'd4);

  // next-state with explicit load enable
  logic             vld_d;
  logic [INT_W-1:0] int_d;
  logic             inv_d;
  logic             inx_d;
  logic             ill_d;

  always_comb begin
    vld_d = in_vld;
    int_d = out_int;
    inv_d = out_invalid;
    inx_d = out_inexact;
    ill_d = out_illegal;
    if (in_vld) begin
      int_d = res;
      inv_d = inv;
      inx_d = inx;
      ill_d = ill;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) out_vld <= 1'b0;
    else         out_vld <= vld_d;
  end

  always_ff @(posedge clk) begin
    out_int     <= int_d;
    out_invalid <= inv_d;
    out_inexact <= inx_d;
    out_illegal <= ill_d;
  end
endmodule

// File: rtl/f2i_conv_chk.sv
module f2i_conv_chk #(
  parameter int INT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_vld,
  input logic [31:0]      in_bits,
  input logic             in_unsigned,
  input logic [2:0]       in_rmode,
  input logic             out_vld,
  input logic [INT_W-1:0] out_int,
  input logic             out_invalid,
  input logic             out_inexact,
  input logic             out_illegal
);
  logic in_nan;
  logic in_zero;
  assign in_nan  = (&in_bits[30:23]) & (|in_bits[22:0]);
  assign in_zero = ~|in_bits[30:0];

  p_vld_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  p_vld_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  p_illegal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> (out_illegal == ($past(in_rmode) > 3'd4)));
  p_flag_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_illegal) |-> !(out_invalid && out_inexact));
  p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_zero && in_rmode <= 3'd4) |=>
      (out_int == '0 && !out_invalid && !out_inexact));
  p_nan_signed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_nan && !in_unsigned && in_rmode <= 3'd4) |=>
      (out_int == {1'b0, {(INT_W-1){1'b1}}} && out_invalid));
  p_nan_unsigned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_nan && in_unsigned && in_rmode <= 3'd4) |=>
      (out_int == {INT_W{1'b1}} && out_invalid));
  p_neg_unsigned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_bits[31] && !in_nan && in_unsigned && in_rmode <= 3'd4) |=>
      (out_int == '0));
endmodule

bind f2i_conv f2i_conv_chk #(.INT_W(INT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_ok),
  .in_vld      (in_vld),
  .in_bits     (in_bits),
  .in_unsigned (in_unsigned),
  .in_rmode    (in_rmode),
  .out_vld     (out_vld),
  .out_int     (out_int),
  .out_invalid (out_invalid),
  .out_inexact (out_inexact),
  .out_illegal (out_illegal)
);

// File: tb/tb_f2i_conv.sv
module tb_f2i_conv;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [31:0] in_bits = '0;
  logic        in_unsigned = 1'b0;
  logic [2:0]  in_rmode = '0;
  logic        out_vld;
  logic [31:0] out_int;
  logic        out_invalid;
  logic        out_inexact;
  logic        out_illegal;

  always #(CLK_PERIOD/2) clk = ~clk;

  f2i_conv dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_bits(in_bits),
    .in_unsigned(in_unsigned), .in_rmode(in_rmode), .out_vld(out_vld),
    .out_int(out_int), .out_invalid(out_invalid), .out_inexact(out_inexact),
    .out_illegal(out_illegal)
  );

  typedef struct {
    logic [31:0] res;
    bit          inv;
    bit          inx;
    bit          ill;
    string       tag;
  } exp_t;

  exp_t        expq[$];
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;
  bit          prev_vld = 0;
  bit          seen = 0;
  logic [31:0] last_int = '0;

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  // behavioural reference in real arithmetic
  function automatic void model(input logic [31:0] b, input bit uns,
                                input logic [2:0] rm, output exp_t e);
    int  ex;
    real a, fl, fr, mg, v, lo, hi;
    bit  s, up;
    s  = b[31];
    ex = int'(b[30:23]);
    e.ill = (rm > 3'd4);
    e.inx = 0;
    if (ex == 255) begin
      e.inv = 1;
      if (b[22:0] != 0 || !s) e.res = uns ? 32'hFFFF_FFFF : 32'h7FFF_FFFF;
      else                    e.res = uns ? 32'h0 : 32'h8000_0000;
      return;
    end
    if (ex == 0) a = real'(b[22:0]) * (2.0 ** (-149.0));
    else         a = (1.0 + real'(b[22:0]) * (2.0 ** (-23.0))) * (2.0 ** real'(ex - 127));
    fl = $floor(a);
    fr = a - fl;
    case (rm)
      3'd0:    up = (fr > 0.5) || (fr == 0.5 && ($floor(fl / 2.0) * 2.0 != fl));
      3'd2:    up = s && (fr > 0.0);
      3'd3:    up = !s && (fr > 0.0);
      3'd4:    up = (fr >= 0.5);
      default: up = 0;
    endcase
    mg = fl + (up ? 1.0 : 0.0);
    v  = s ? -mg : mg;
    lo = uns ? 0.0 : -2147483648.0;
    hi = uns ? 4294967295.0 : 2147483647.0;
    if (v < lo) begin
      e.inv = 1; e.res = uns ? 32'h0 : 32'h8000_0000;
    end else if (v > hi) begin
      e.inv = 1; e.res = uns ? 32'hFFFF_FFFF : 32'h7FFF_FFFF;
    end else begin
      longint li;
      e.inv = 0;
      li    = longint'(v);
      e.res = li[31:0];
      e.inx = (mg != a);
    end
  endfunction

  task automatic drive(input logic [31:0] b, input bit uns,
                       input logic [2:0] rm, input string tag);
    exp_t e;
    @(negedge clk);
    model(b, uns, rm, e);
    e.tag       = tag;
    in_vld      = 1'b1;
    in_bits     = b;
    in_unsigned = uns;
    in_rmode    = rm;
    expq.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_vld = 1'b0;
    end
  endtask

  always @(posedge clk) prev_vld <= in_vld;

  // compare on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (out_vld !== prev_vld) begin
        n_bad++;
        $display("FAIL R11 out_vld actual=%b expected=%b", out_vld, prev_vld);
      end
      if (prev_vld && expq.size() > 0) begin
        exp_t e;
        e = expq.pop_front();
        n_chk++;
        if (e.ill) begin
          if (out_illegal !== 1'b1) begin
            n_bad++;
            $display("FAIL R10 illegal actual=%b expected=1", out_illegal);
          end
        end else if (out_int !== e.res || out_invalid !== e.inv ||
                     out_inexact !== e.inx || out_illegal !== 1'b0) begin
          n_bad++;
          $display("FAIL %s actual=%h inv=%b inx=%b ill=%b expected=%h inv=%b inx=%b ill=0",
                   e.tag, out_int, out_invalid, out_inexact, out_illegal,
                   e.res, e.inv, e.inx);
        end
        seen     = 1;
        last_int = out_int;
      end else if (seen) begin
        n_chk++;
        if (out_int !== last_int) begin
          n_bad++;
          $display("FAIL R12 hold actual=%h expected=%h", out_int, last_int);
        end
      end
    end
  end

  initial begin
    logic [31:0] vals [NV] = '{
      32'h3FC0_0000, 32'h4020_0000, 32'hC020_0000, 32'h3F00_0000,
      32'hBF00_0000, 32'hBECC_CCCD, 32'h4F00_0000, 32'hCF00_0000,
      32'h4F80_0000, 32'h4F7F_FFFF, 32'h4EFF_FFFF, 32'hBF80_0000,
      32'h7F80_0000, 32'hFF80_0000, 32'h7FC0_0000, 32'h7F80_0001,
      32'h0000_0000, 32'h8000_0000, 32'h0000_0001, 32'h8000_0001,
      32'h47F1_2065, 32'hC7F1_2065, 32'h3F40_0000, 32'hCF00_0001};
    string tags [NV] = '{
      "R1", "R1", "R1", "R1", "R6", "R6", "R4", "R6",
      "R5", "R3", "R2", "R3", "R4", "R4", "R4", "R5",
      "R8", "R8", "R9", "R9", "R7", "R2", "R1", "R4"};
    int cnt = 0;

    // R13: valid low during reset
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_vld !== 1'b0) begin
      n_bad++;
      $display("FAIL R13 out_vld actual=%b expected=0", out_vld);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int rm = 0; rm < 5; rm++) begin
      for (int u = 0; u < 2; u++) begin
        for (int i = 0; i < NV; i++) begin
          drive(vals[i], u[0], rm[2:0], tags[i]);
          cnt++;
          if (cnt % 7 == 0) idle(2);
        end
      end
    end
    for (int rm = 5; rm < 8; rm++) begin
      drive(32'h3FC0_0000, 1'b0, rm[2:0], "R10");
      idle(1);
    end
    idle(3);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule